// File: doc/BRIEF.md
# Fraction-Dithered Multi-Channel PWM DAC

This block drives several slow, high-resolution DAC channels from pulse-width modulated outputs. Each channel holds a setpoint made of a coarse on-time and a sub-clock fraction. The coarse part sets how many clocks of each PWM period the output stays high. The fraction is fed once per period into a first-order error-feedback accumulator. When that accumulator overflows, the period's pulse is one clock longer. The average on-time therefore resolves the fraction over many periods, and the counter does not need to be any wider.

All channels share one free-running period counter. Software loads setpoints through a small write port into per-channel shadow registers. A channel picks up its shadow value only at a period boundary, so each pulse is built from one consistent setpoint. Every channel also drives a complementary output with identical timing. Pairing the two keeps the total switching current of an external driver roughly constant. The outputs are meant to feed an external level shifter and RC filter.

Top module: `pwm_ds_dac`

## Requirements
- R1: One shared counter of COARSE_W bits holds 0 while reset is high. It then steps by one every clock and wraps from 2^COARSE_W-1 to 0, so a period is 2^COARSE_W clocks.
- R2: A setpoint is COARSE_W+FRAC_W bits wide. Bits [COARSE_W+FRAC_W-1:FRAC_W] are the coarse on-time and bits [FRAC_W-1:0] are the fraction. A clock with wr_en high stores wr_data in the shadow register of channel wr_addr.
- R3: A channel copies its shadow into its active setpoint only on the clock edge where the counter equals its maximum. A write made earlier in a period leaves that period's pulse unchanged and governs the next period.
- R4: On that same boundary edge the channel adds the shadow fraction to its FRAC_W-bit residue. The carry-out lengthens the next pulse by one clock, and the sum modulo 2^FRAC_W becomes the new residue. Loading a new setpoint never clears the residue.
- R5: The output is registered. In the clock after an edge at which the counter held value c, the output is high exactly when c < coarse + carry. Each pulse therefore starts at period position 0 and lasts coarse + carry clocks.
- R6: Coarse 0 with no carry gives a period that is low throughout. The maximum coarse value with a carry gives a period that is high throughout.
- R7: Over any 256 consecutive periods with a fixed setpoint and FRAC_W = 8, the output is high for exactly 256*coarse + fraction clocks.
- R8: pwm_out_n is always the bitwise inverse of pwm_out.
- R9: Synchronous reset clears the counter, shadows, active setpoints, residues and carries. While reset is high and in the first clock after it, pwm_out is all zeros and pwm_out_n is all ones.
- R10: A write to an address of CHANNELS or above changes no channel, and a write to one channel leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Setpoint write strobe |
| wr_addr | input | ADDR_W | Channel index for the write |
| wr_data | input | COARSE_W+FRAC_W | Setpoint: coarse above, fraction below |
| pwm_out | output | CHANNELS | True PWM outputs |
| pwm_out_n | output | CHANNELS | Complementary PWM outputs |

## Verification
The assertions assume that wr_addr and wr_data carry known values in every clock where wr_en is high. They also assume that reset is held long enough for the registered outputs to settle before the first check. The bench meets both conditions. It holds reset for several clocks from time zero and drives the write port only at falling edges with fully defined values. It makes each write early in a period, well before the boundary edge, so every write lands in a known period.

// File: rtl/pwm_ds_dac.sv
module pwm_ds_dac #(
  parameter int CHANNELS = 10,
  parameter int COARSE_W = 14,
  parameter int FRAC_W   = 8,
  localparam int ADDR_W  = (CHANNELS > 1) ? $clog2(CHANNELS) : 1,
  localparam int SET_W   = COARSE_W + FRAC_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [SET_W-1:0]    wr_data,
  output logic [CHANNELS-1:0] pwm_out,
  output logic [CHANNELS-1:0] pwm_out_n
);

  logic [COARSE_W-1:0] cnt;
  logic                wrap;

  assign wrap = &cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  for (genvar g = 0; g < CHANNELS; g++) begin : g_ch
    logic [SET_W-1:0]    shadow;
    logic [COARSE_W-1:0] coarse;
    logic [FRAC_W-1:0]   resid;
    logic                ext;
    logic                on_q;
    logic [FRAC_W:0]     sum;
    logic                on_d;

    assign sum  = {1'b0, resid} + {1'b0, shadow[FRAC_W-1:0]};
    assign on_d = {1'b0, cnt} < ({1'b0, coarse} + {{COARSE_W{1'b0}}, ext});

    always_ff @(posedge clk) begin
      if (rst) begin
        shadow <= '0;
        coarse <= '0;
        resid  <= '0;
        ext    <= 1'b0;
        on_q   <= 1'b0;
      end else begin
        if (wr_en && wr_addr == ADDR_W'(g)) shadow <= wr_data;
        if (wrap) begin
          coarse <= shadow[SET_W-1:FRAC_W];
          resid  <= sum[FRAC_W-1:0];
          ext    <= sum[FRAC_W];
        end
        on_q <= on_d;
      end
    end

    assign pwm_out[g]   = on_q;
    assign pwm_out_n[g] = ~on_q;
  end

endmodule

module pwm_ds_dac_chk #(
  parameter int CHANNELS = 10,
  parameter int COARSE_W = 14,
  parameter int FRAC_W   = 8,
  localparam int ADDR_W  = (CHANNELS > 1) ? $clog2(CHANNELS) : 1,
  localparam int SET_W   = COARSE_W + FRAC_W
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic [ADDR_W-1:0]   wr_addr,
  input logic [SET_W-1:0]    wr_data,
  input logic [COARSE_W-1:0] cnt,
  input logic [CHANNELS-1:0] pwm_out,
  input logic [CHANNELS-1:0] pwm_out_n
);

  logic started = 1'b0;
  always_ff @(posedge clk) started <= 1'b1;

  a_r1_count_step: assert property (@(posedge clk) disable iff (rst)
    (started && !$past(rst)) |-> cnt == COARSE_W'($past(cnt) + 1'b1));

  a_r9_reset_outputs: assert property (@(posedge clk)
    (started && $past(rst)) |-> (pwm_out == '0 && pwm_out_n == '1));

  a_r2_write_known: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !$isunknown({wr_addr, wr_data}));

  for (genvar i = 0; i < CHANNELS; i++) begin : g_a
    a_r5_rise_at_start: assert property (@(posedge clk) disable iff (rst)
      (started && $rose(pwm_out[i])) |-> $past(cnt) == '0);
  end

endmodule

bind pwm_ds_dac pwm_ds_dac_chk #(
  .CHANNELS(CHANNELS), .COARSE_W(COARSE_W), .FRAC_W(FRAC_W)
) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .cnt(cnt), .pwm_out(pwm_out), .pwm_out_n(pwm_out_n)
);

// File: tb/pwm_ds_dac_tb_top.sv
module pwm_ds_dac_tb_top;
  localparam int CH  = 3;
  localparam int CW  = 5;
  localparam int FW  = 8;
  localparam int P   = 1 << CW;
  localparam int AW  = 2;
  localparam int SW  = CW + FW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [SW-1:0] wr_data = '0;
  logic [CH-1:0] pwm_out, pwm_out_n;

  int tests = 0, fails = 0, m = 0;
  int hi [CH];
  bit first [CH];
  bit comp_ok;
  bit done = 0;

  always #10 clk = ~clk;

  always @(posedge clk) if (rst) m <= 0; else m <= m + 1;

  pwm_ds_dac #(.CHANNELS(CH), .COARSE_W(CW), .FRAC_W(FW)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_out(pwm_out), .pwm_out_n(pwm_out_n));

  function automatic logic [SW-1:0] sp(int c, int f);
    return SW'((c << FW) | f);
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic write(int a, logic [SW-1:0] d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // one full period per call; optional write at position 2
  task automatic measure(bit do_wr = 0, int a = 0, logic [SW-1:0] d = '0);
    while (!(m >= 1 && (m - 1) % P == 0)) @(negedge clk);
    comp_ok = 1;
    for (int c = 0; c < CH; c++) begin hi[c] = 0; first[c] = pwm_out[c]; end
    for (int i = 0; i < P; i++) begin
      if (do_wr && i == 2) begin wr_en = 1'b1; wr_addr = AW'(a); wr_data = d; end
      if (i == 3) wr_en = 1'b0;
      for (int c = 0; c < CH; c++) hi[c] += int'(pwm_out[c]);
      if (pwm_out_n !== ~pwm_out) comp_ok = 0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 out in reset", int'(pwm_out), 0);
    check("R9 out_n in reset", int'(pwm_out_n), (1 << CH) - 1);
    rst = 1'b0;
    @(negedge clk);
    check("R9 out after reset", int'(pwm_out), 0);
    check("R1 counter starts at 0 -> out low", int'(pwm_out_n), (1 << CH) - 1);
  endtask

  task automatic t_coarse();
    do_reset();
    write(0, sp(10, 0));
    write(1, sp(3, 0));
    measure();
    check("R5 ch0 on-time", hi[0], 10);
    check("R5 pulse starts at position 0", int'(first[0]), 1);
    check("R2 ch1 on-time", hi[1], 3);
    check("R10 ch2 untouched", hi[2], 0);
    check("R8 complement", int'(comp_ok), 1);
    measure(1, 3, sp(15, 0));
    measure();
    check("R10 addr 3 ignored ch0", hi[0], 10);
    check("R10 addr 3 ignored ch1", hi[1], 3);
    check("R10 addr 3 ignored ch2", hi[2], 0);
  endtask

  task automatic t_half();
    do_reset();
    write(0, sp(5, 128));
    measure();
    check("R4 half fraction period 1", hi[0], 5);
    measure();
    check("R4 half fraction period 2", hi[0], 6);
  endtask

  task automatic t_residue_kept();
    do_reset();
    write(0, sp(5, 128));
    measure(1, 0, sp(9, 128));
    check("R3 mid-period write not applied yet", hi[0], 5);
    measure();
    check("R4 residue kept across update", hi[0], 10);
  endtask

  task automatic t_midwrite();
    do_reset();
    write(1, sp(4, 0));
    measure();
    check("R3 before write", hi[1], 4);
    measure(1, 1, sp(20, 0));
    check("R3 period of write unchanged", hi[1], 4);
    measure();
    check("R3 next period uses new value", hi[1], 20);
  endtask

  task automatic t_extremes();
    do_reset();
    write(0, sp(0, 0));
    write(1, sp(P - 1, 255));
    measure();
    check("R6 zero setpoint low", hi[0], 0);
    check("R6 max coarse no carry", hi[1], P - 1);
    measure();
    check("R6 zero setpoint still low", hi[0], 0);
    check("R6 max coarse with carry full high", hi[1], P);
    check("R8 complement at extremes", int'(comp_ok), 1);
  endtask

  task automatic t_sum(int c, int f);
    int total = 0;
    do_reset();
    write(2, sp(c, f));
    for (int k = 0; k < 256; k++) begin
      measure();
      total += hi[2];
    end
    check("R7 256-period on-time total", total, 256 * c + f);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(20ns * 200000);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_coarse();
    t_half();
    t_residue_kept();
    t_midwrite();
    t_extremes();
    t_sum(7, 37);
    t_sum(20, 255);
    t_sum(0, 1);
    finish_run();
  end
endmodule